// File: doc/BRIEF.md
# Two-Wire Target for Clock Registers and Scratch Memory

This block is a target (slave) on a two-wire serial bus. It gives a bus controller read and write access to a bank of time-of-day registers and to a 31-byte scratch memory. The block has no storage of its own for that data. Both stores sit outside it, behind a plain parallel port with a registered write strobe and a combinational read path. A system clock oversamples the SCL and SDA lines, which must run at least sixteen times the SCL rate. Each line passes through a two-stage synchronizer before any edge is decoded.

Every access is one frame:
- a START condition;
- the target identifier with its direction bit;
- a command byte that selects the store, the access length and the starting address;
- then data bytes, written by the controller or returned by the target.

A single access moves exactly one data byte. A burst access keeps moving bytes at successive addresses, wrapping inside the selected store, until the controller stops it. A START at any point throws away the frame in progress. The block never answers the general-call identifier. The SDA output is an open-drain enable: when it is high, the pad pulls the line low.

Top module: `rtc_i2c_target`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. After reset, and after any STOP, the block leaves SDA released (`sda_oe` = 0) and issues no write.
- R2: The first byte after START carries the identifier 7'b1010000 in bits 7:1 and the direction in bit 0 (1 = read). A matching identifier is acknowledged. Any other identifier is not acknowledged, and every byte after it is ignored until the next START.
- R3: The general-call identifier 7'b0000000 is never acknowledged, and no write follows it.
- R4: The command byte has this layout:
  - bit 7 selects the store (0 = clock registers, 1 = scratch memory);
  - bit 6 selects burst mode;
  - bits 4:0 give the starting address;
  - bit 5 is ignored.

  A command whose address is not below the store size (8 clock registers, 31 scratch bytes) is not acknowledged, and the frame is then ignored.
- R5: In a single write, the first data byte is acknowledged and written to the addressed location. Any further data byte in the same frame is not acknowledged and not written.
- R6: In a single read, the target sends the addressed byte MSB first, starting right after the command acknowledge. If the controller asks for more, the target leaves SDA released, so those bytes read as 8'hFF.
- R7: In a burst write, each data byte is acknowledged and written to the next address. After the last address of the selected store, the address wraps to 0.
- R8: In a burst read, each byte the controller acknowledges advances the address by one, with the same wrap, and the next byte is sent from the new address.
- R9: When the controller does not acknowledge a read byte, the target stops sending and keeps SDA released until the next START.
- R10: A START in the middle of a frame aborts it. The next byte is treated as the identifier, and the aborted partial byte is never written.
- R11: Every accepted write byte produces exactly one single-cycle `acc_wr` pulse, carrying the store select, the address and the data of that byte.
- R12: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 = pull SDA low |
| acc_sel | output | 1 | Store select: 0 = clock registers, 1 = scratch memory |
| acc_addr | output | 5 | Address inside the selected store |
| acc_wr | output | 1 | Single-cycle write strobe |
| acc_wdata | output | 8 | Write data |
| acc_rdata | input | 8 | Read data for `acc_sel`/`acc_addr`, combinational |

## Verification
Each line passes through two synchronizer stages, and the edge-decode register adds one more. So `sda_oe` and `acc_wr` react on the third system-clock edge after the SCL edge that causes them. The acknowledge for a byte therefore appears three cycles after the eighth falling SCL edge, and the next transmitted bit appears three cycles after each falling edge.

The bench moves SCL only every five system clocks. It reads SDA at the middle of each SCL-high phase, at least twelve cycles after any change the target can make. A per-clock model in the bench matches every `acc_wr` pulse, in the cycle it appears, against a queue of expected writes. In frames where the target must stay silent, the model also checks on every clock that SDA is released.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

    localparam int AW = 5;
    localparam logic [6:0] TARGET_ID = 7'b1010000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_SKIP
    } phase_e;

    typedef struct packed {
        logic          sram;
        logic          burst;
        logic [AW-1:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.sram  = b[7];
        c.burst = b[6];
        c.addr  = b[AW-1:0];
        return c;
    endfunction

    function automatic logic addr_ok(input cmd_t c, input int nclk, input int nsram);
        int lim;
        lim = c.sram ? nsram : nclk;
        return int'(c.addr) < lim;
    endfunction

endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl,
    output logic sda,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= '1;
            else     ff <= {ff[STAGES-2:0], raw[l]};
        end
        assign synced[l] = ff[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    assign scl       = synced[0];
    assign sda       = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/rtc_i2c_addr.sv
module rtc_i2c_addr #(
    parameter int NCLK  = 8,
    parameter int NSRAM = 31,
    parameter int AW    = 5
) (
    input  logic          sram,
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] LAST_C = AW'(NCLK - 1);
    localparam logic [AW-1:0] LAST_S = AW'(NSRAM - 1);

    logic [AW-1:0] last;

    always_comb begin
        last = sram ? LAST_S : LAST_C;
        nxt  = (cur == last) ? '0 : cur + 1'b1;
    end

endmodule

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target
    import rtc_i2c_pkg::*;
#(
    parameter logic [6:0] ID          = TARGET_ID,
    parameter int         NCLK        = 8,
    parameter int         NSRAM       = 31,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          acc_sel,
    output logic [AW-1:0] acc_addr,
    output logic          acc_wr,
    output logic [7:0]    acc_wdata,
    input  logic [7:0]    acc_rdata
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    logic   scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
    phase_e st;
    logic   ack_ph, rw, used, mack;
    logic [3:0]    cnt;
    logic [7:0]    shreg;
    cmd_t          cmd;
    cmd_t          cmd_in;
    logic [AW-1:0] nxt_addr;

    rtc_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .scl       (scl_s),
        .sda       (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    rtc_i2c_addr #(.NCLK(NCLK), .NSRAM(NSRAM), .AW(AW)) u_addr (
        .sram (cmd.sram),
        .cur  (cmd.addr),
        .nxt  (nxt_addr)
    );

    assign cmd_in   = decode_cmd(shreg);
    assign acc_sel  = cmd.sram;
    assign acc_addr = cmd.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ack_ph    <= 1'b0;
            rw        <= 1'b0;
            used      <= 1'b0;
            mack      <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            cmd       <= '0;
            sda_oe    <= 1'b0;
            acc_wr    <= 1'b0;
            acc_wdata <= '0;
        end else begin
            acc_wr <= 1'b0;
            if (start_det) begin
                st     <= ST_ID;
                cnt    <= '0;
                ack_ph <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                ack_ph <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ID, ST_CMD, ST_WR: begin
                        if (!ack_ph) begin
                            if (scl_rise && cnt < LAST_BIT) begin
                                shreg <= {shreg[6:0], sda_s};
                                cnt   <= cnt + 1'b1;
                            end else if (scl_fall && cnt == LAST_BIT) begin
                                if (st == ST_ID) begin
                                    if (shreg[7:1] == ID) begin
                                        sda_oe <= 1'b1;
                                        ack_ph <= 1'b1;
                                        rw     <= shreg[0];
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end else if (st == ST_CMD) begin
                                    if (addr_ok(cmd_in, NCLK, NSRAM)) begin
                                        sda_oe <= 1'b1;
                                        ack_ph <= 1'b1;
                                        cmd    <= cmd_in;
                                        used   <= 1'b0;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end else begin
                                    if (!used || cmd.burst) begin
                                        sda_oe    <= 1'b1;
                                        ack_ph    <= 1'b1;
                                        acc_wr    <= 1'b1;
                                        acc_wdata <= shreg;
                                        used      <= 1'b1;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                            end
                        end else if (scl_fall) begin
                            ack_ph <= 1'b0;
                            cnt    <= '0;
                            if (st == ST_ID) begin
                                st     <= ST_CMD;
                                sda_oe <= 1'b0;
                            end else if (st == ST_CMD) begin
                                if (rw) begin
                                    st     <= ST_RD;
                                    shreg  <= acc_rdata;
                                    sda_oe <= ~acc_rdata[7];
                                end else begin
                                    st     <= ST_WR;
                                    sda_oe <= 1'b0;
                                end
                            end else begin
                                sda_oe <= 1'b0;
                                if (cmd.burst) cmd.addr <= nxt_addr;
                            end
                        end
                    end
                    ST_RD: begin
                        if (!ack_ph) begin
                            if (scl_rise) begin
                                cnt <= cnt + 1'b1;
                            end else if (scl_fall) begin
                                if (cnt == LAST_BIT) begin
                                    sda_oe <= 1'b0;
                                    ack_ph <= 1'b1;
                                end else begin
                                    shreg  <= {shreg[6:0], 1'b1};
                                    sda_oe <= ~shreg[6];
                                end
                            end
                        end else begin
                            if (scl_rise) begin
                                mack <= ~sda_s;
                                if (!sda_s && cmd.burst) cmd.addr <= nxt_addr;
                            end else if (scl_fall) begin
                                if (!mack) begin
                                    st <= ST_IDLE;
                                end else if (cmd.burst) begin
                                    shreg  <= acc_rdata;
                                    sda_oe <= ~acc_rdata[7];
                                    cnt    <= '0;
                                    ack_ph <= 1'b0;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rtc_i2c_target_chk.sv
module rtc_i2c_target_chk #(
    parameter int NCLK  = 8,
    parameter int NSRAM = 31
) (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       acc_wr,
    input logic       acc_sel,
    input logic [4:0] acc_addr
);
    // R12: the data line only moves while clock is low
    p_sda_low_phase_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R1: STOP leaves the line released
    p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R10: START aborts and releases
    p_start_release_r10: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    // R11: write strobe lasts one cycle
    p_wr_single_r11: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> !acc_wr);

    // R4: writes stay inside the selected store
    p_addr_range_r4: assert property (@(posedge clk) disable iff (rst)
        acc_wr |-> (int'(acc_addr) < (acc_sel ? NSRAM : NCLK)));

    // R5: every accepted write byte is acknowledged
    p_wr_acked_r5: assert property (@(posedge clk) disable iff (rst)
        acc_wr |-> sda_oe);

endmodule

bind rtc_i2c_target rtc_i2c_target_chk #(.NCLK(NCLK), .NSRAM(NSRAM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .acc_addr  (acc_addr)
);

// File: tb/rtc_i2c_target_bench.sv
module rtc_i2c_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe, acc_sel, acc_wr;
    logic [4:0] acc_addr;
    logic [7:0] acc_wdata, acc_rdata;
    logic       sda_line;

    logic [7:0] clk_mem  [8];
    logic [7:0] sram_mem [31];

    int checks = 0;
    int errors = 0;
    bit quiet = 0;
    bit done  = 0;
    logic [13:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    always_comb begin
        if (acc_sel) acc_rdata = (acc_addr < 5'd31) ? sram_mem[acc_addr] : 8'h00;
        else         acc_rdata = (acc_addr < 5'd8)  ? clk_mem[acc_addr[2:0]] : 8'h00;
    end

    always @(posedge clk) begin
        if (acc_wr) begin
            if (acc_sel) sram_mem[acc_addr] <= acc_wdata;
            else         clk_mem[acc_addr[2:0]] <= acc_wdata;
        end
    end

    rtc_i2c_target u_rtc_i2c_target (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .acc_sel   (acc_sel),
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock model: write strobes against the queue, silence where required
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (acc_wr) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected write", int'({acc_sel, acc_addr, acc_wdata}), 0);
                end else begin
                    logic [13:0] e;
                    e = exp_q.pop_front();
                    chk({acc_sel, acc_addr, acc_wdata} == e, "R11 write content",
                        int'({acc_sel, acc_addr, acc_wdata}), int'(e));
                end
            end
            if (quiet && sda_oe) chk(0, "R2/R9 target must stay silent", 1, 0);
        end
    end

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half();
        m_scl = 1'b1; half();
        m_sda = 1'b0; half();
        m_scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half();
        m_scl = 1'b1; half();
        m_sda = 1'b1; half();
        half();
    endtask

    task automatic wbit(input logic b);
        m_sda = b;    half();
        m_scl = 1'b1; half();
        half();
        m_scl = 1'b0; half();
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; half();
        m_scl = 1'b1; half();
        b = sda_line; half();
        m_scl = 1'b0; half();
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(!mack);
    endtask

    function automatic logic [13:0] wr_ent(input logic s, input logic [4:0] a, input logic [7:0] d);
        return {s, a, d};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < 8; i++)  clk_mem[i]  = 8'h00;
        for (int i = 0; i < 31; i++) sram_mem[i] = 8'h00;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!sda_oe && !acc_wr, "R1 reset state released", int'(sda_oe), 0);

        // R5 single write clock reg 3, extra byte refused
        bus_start();
        send_byte(8'hA0, ack); chk(ack, "R2 ID ack", ack, 1);
        send_byte(8'h03, ack); chk(ack, "R4 cmd ack", ack, 1);
        exp_q.push_back(wr_ent(1'b0, 5'd3, 8'h45));
        send_byte(8'h45, ack); chk(ack, "R5 data ack", ack, 1);
        send_byte(8'h99, ack); chk(!ack, "R5 second byte nack", ack, 0);
        bus_stop();
        chk(!sda_oe, "R1 released after STOP", int'(sda_oe), 0);

        // R6 single read
        bus_start();
        send_byte(8'hA1, ack); chk(ack, "R2 ID read ack", ack, 1);
        send_byte(8'h03, ack); chk(ack, "R4 cmd ack", ack, 1);
        recv_byte(d, 1'b1); chk(d == 8'h45, "R6 single read data", d, 8'h45);
        recv_byte(d, 1'b0); chk(d == 8'hFF, "R6 extra byte idle", d, 8'hFF);
        bus_stop();

        // R2 foreign identifier
        quiet = 1;
        bus_start();
        send_byte(8'h52, ack); chk(!ack, "R2 foreign ID nack", ack, 0);
        send_byte(8'h03, ack); chk(!ack, "R2 ignored after foreign ID", ack, 0);
        bus_stop();
        // R3 general call
        bus_start();
        send_byte(8'h00, ack); chk(!ack, "R3 general call nack", ack, 0);
        send_byte(8'h01, ack); chk(!ack, "R3 no follow-up", ack, 0);
        bus_stop();
        quiet = 0;

        // R4 range checks
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h08, ack); chk(!ack, "R4 clock addr 8 nack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h9F, ack); chk(!ack, "R4 scratch addr 31 nack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'hBE, ack); chk(ack, "R4 bit5 ignored addr 30 ack", ack, 1);
        exp_q.push_back(wr_ent(1'b1, 5'd30, 8'h77));
        send_byte(8'h77, ack); chk(ack, "R4 write scratch 30", ack, 1);
        bus_stop();

        // R7 burst write scratch from 29, wraps
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'hDD, ack); chk(ack, "R7 burst cmd ack", ack, 1);
        exp_q.push_back(wr_ent(1'b1, 5'd29, 8'h11));
        exp_q.push_back(wr_ent(1'b1, 5'd30, 8'h22));
        exp_q.push_back(wr_ent(1'b1, 5'd0,  8'h33));
        exp_q.push_back(wr_ent(1'b1, 5'd1,  8'h44));
        send_byte(8'h11, ack); chk(ack, "R7 burst byte 0", ack, 1);
        send_byte(8'h22, ack); chk(ack, "R7 burst byte 1", ack, 1);
        send_byte(8'h33, ack); chk(ack, "R7 burst wrap byte", ack, 1);
        send_byte(8'h44, ack); chk(ack, "R7 burst byte 3", ack, 1);
        bus_stop();
        chk(exp_q.size() == 0, "R7 all burst writes seen", exp_q.size(), 0);

        // R8 burst read, R9 NACK end
        bus_start();
        send_byte(8'hA1, ack);
        send_byte(8'hDD, ack);
        recv_byte(d, 1'b1); chk(d == 8'h11, "R8 burst read 29", d, 8'h11);
        recv_byte(d, 1'b1); chk(d == 8'h22, "R8 burst read 30", d, 8'h22);
        recv_byte(d, 1'b1); chk(d == 8'h33, "R8 burst read wrap 0", d, 8'h33);
        recv_byte(d, 1'b0); chk(d == 8'h44, "R8 burst read 1", d, 8'h44);
        quiet = 1;
        half(); half();
        chk(sda_line, "R9 released after NACK", int'(sda_line), 1);
        bus_stop();
        quiet = 0;

        // R7/R8 clock-register wrap at 8
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h46, ack);
        exp_q.push_back(wr_ent(1'b0, 5'd6, 8'hA6));
        exp_q.push_back(wr_ent(1'b0, 5'd7, 8'hB7));
        exp_q.push_back(wr_ent(1'b0, 5'd0, 8'hC0));
        send_byte(8'hA6, ack);
        send_byte(8'hB7, ack);
        send_byte(8'hC0, ack); chk(ack, "R7 clock wrap ack", ack, 1);
        bus_stop();
        bus_start();
        send_byte(8'hA1, ack);
        send_byte(8'h47, ack);
        recv_byte(d, 1'b1); chk(d == 8'hB7, "R8 clock read 7", d, 8'hB7);
        recv_byte(d, 1'b0); chk(d == 8'hC0, "R8 clock read wrap 0", d, 8'hC0);
        bus_stop();

        // R10 START mid-byte aborts
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h05, ack);
        wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
        bus_start();
        send_byte(8'hA0, ack); chk(ack, "R10 ID after restart", ack, 1);
        send_byte(8'h05, ack); chk(ack, "R10 cmd after restart", ack, 1);
        exp_q.push_back(wr_ent(1'b0, 5'd5, 8'h5A));
        send_byte(8'h5A, ack); chk(ack, "R10 data after restart", ack, 1);
        bus_stop();
        half();
        chk(exp_q.size() == 0, "R10 no stray write", exp_q.size(), 0);
        chk(clk_mem[5] == 8'h5A, "R11 store holds written byte", clk_mem[5], 8'h5A);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule